// File: doc/BRIEF.md
# Serial Dual-Channel DAC Code Loader

This block takes code words for two 8-bit converter channels over a slow three-wire serial link and keeps them in a two-level register bank. The link has a gated serial clock that idles low, a data line and a load strobe. A fast system clock oversamples all three lines. Each frame is ten bits long and is sent most significant bit first. The upper two bits name a channel and the lower eight bits are that channel's code. A complete frame writes the code into the channel's staging latch. A rising edge on the load strobe then copies both staging latches into the output registers on the same cycle, so the two channels change together.

The outputs are the two offset-binary codes, with 0x80 at mid-scale, and the same codes in two's complement form. An active-low power-down input raises a standby flag for both channels. While the block is in standby it still accepts frames and strobes. A frame that names channel 2 or 3 is dropped and raises a one-cycle error pulse. A load strobe that arrives partway through a frame throws away the bits received so far.

The receiver is a three-state machine. `ST_IDLE` moves to `ST_SHIFT` on the first serial-clock rising edge. `ST_SHIFT` moves to `ST_DONE` on the tenth edge, or back to `ST_IDLE` on a strobe edge. `ST_DONE` returns to `ST_IDLE` unconditionally after one cycle, and that is the cycle in which the latch write or the error pulse happens.

Top module: `sdac_load_if`

## Requirements
- R1: After reset, both staging latches and both output codes are 0x80 and the error flag is low.
- R2: A data bit is taken on each rising edge of the serial clock. Ten edges make one frame, first bit most significant. Frame bits [9:8] are the channel select and bits [7:0] are the code.
- R3: A completed frame with select 0 writes staging latch 0, which drives `code_o[7:0]` after a strobe. Select 1 writes staging latch 1, which drives `code_o[15:8]`. The output codes do not change until a strobe arrives.
- R4: A rising edge on the strobe copies both staging latches into the output registers in the same cycle. Without a strobe edge the output codes hold their values.
- R5: A frame with select 2 or 3 changes no latch and no output code. It raises `frame_err_o` for exactly one cycle.
- R6: A strobe edge during a partly received frame discards that frame's bits, and the next frame is received from its first bit.
- R7: `code_signed_o` equals `code_o` with the top bit of each channel's byte inverted.
- R8: `standby_o` is high while `pwrdn_n_i` is low. Frames and strobes are still processed in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Gated serial clock, idles low |
| sdata_i | input | 1 | Serial data, taken on the serial-clock rising edge |
| latch_i | input | 1 | Load strobe, acts on its rising edge |
| pwrdn_n_i | input | 1 | Active-low power-down request |
| code_o | output | 16 | Output codes, offset binary, channel 1 in the upper byte |
| code_signed_o | output | 16 | Output codes in two's complement |
| standby_o | output | 1 | Standby flag for both channels |
| frame_err_o | output | 1 | One-cycle pulse when a frame names an unused channel |

## Verification
The assertions assume that every level of the serial clock and the strobe lasts several system clocks. Under that assumption each edge is seen exactly once, a frame end is never followed by another serial edge within a cycle, and the bit counter stays below ten. They also assume that the strobe is not pulsed while the final bit of a frame is being committed. The stimulus holds every serial-clock phase and every strobe pulse for four system clocks and leaves idle time around each strobe. This keeps it inside those assumptions, and the cycle-level model in the bench follows the same ordering.

// File: rtl/sdac_pkg.sv
`timescale 1ns/1ps
package sdac_pkg;
    localparam int SDAC_CODE_W = 8;
    localparam int SDAC_SEL_W  = 2;
    localparam int SDAC_NUM_CH = 2;
    localparam int SDAC_SYNC   = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } rx_state_t;
endpackage

// File: rtl/sdac_sync.sv
`timescale 1ns/1ps
module sdac_sync #(
    parameter int WIDTH    = 1,
    parameter int STAGES   = 2,
    parameter bit EDGE_OUT = 1'b0,
    localparam int DEPTH   = EDGE_OUT ? STAGES + 1 : STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] pipe_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
        end else begin
            pipe_q[0] <= async_i;
            for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    // Level variant passes the synchronized value; edge variant flags a rise.
    generate
        if (EDGE_OUT) begin : g_edge
            assign sync_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
        end else begin : g_lvl
            assign sync_o = pipe_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sdac_frame_rx.sv
`timescale 1ns/1ps
module sdac_frame_rx
    import sdac_pkg::*;
#(
    parameter int SEL_W    = 2,
    parameter int CODE_W   = 8,
    parameter int NUM_CH   = 2,
    localparam int FRAME_W = SEL_W + CODE_W,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_rise,
    input  logic              bit_val,
    input  logic              strobe_rise,
    output logic              wr_en,
    output logic [SEL_W-1:0]  wr_sel,
    output logic [CODE_W-1:0] wr_code,
    output logic              frame_err,
    output logic [CNT_W-1:0]  bit_cnt
);
    rx_state_t          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] shreg_q;
    logic               last_bit;
    logic [SEL_W-1:0]   sel;
    logic               sel_ok;

    assign last_bit = (cnt_q == CNT_W'(FRAME_W - 1));
    assign sel      = shreg_q[FRAME_W-1 -: SEL_W];
    assign sel_ok   = (int'(sel) < NUM_CH);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!strobe_rise && bit_rise) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (strobe_rise)                state_d = ST_IDLE;
                else if (bit_rise && last_bit)  state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bit counter and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
        end else begin
            unique case (state_q)
                ST_DONE: cnt_q <= '0;
                default: begin
                    if (strobe_rise) begin
                        cnt_q <= '0;
                    end else if (bit_rise) begin
                        shreg_q <= {shreg_q[FRAME_W-2:0], bit_val};
                        cnt_q   <= last_bit ? '0 : cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Outputs from the state
    always_comb begin
        wr_en     = 1'b0;
        frame_err = 1'b0;
        unique case (state_q)
            ST_DONE: begin
                wr_en     = sel_ok;
                frame_err = !sel_ok;
            end
            default: ;
        endcase
    end

    assign wr_sel  = sel;
    assign wr_code = shreg_q[CODE_W-1:0];
    assign bit_cnt = cnt_q;
endmodule

// File: rtl/sdac_bank.sv
`timescale 1ns/1ps
module sdac_bank #(
    parameter int NUM_CH  = 2,
    parameter int CODE_W  = 8,
    parameter int SEL_W   = 2,
    localparam int BUS_W  = NUM_CH * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              load,
    output logic [BUS_W-1:0]  lat_bus,
    output logic [BUS_W-1:0]  out_bus
);
    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic [CODE_W-1:0] lat_q, out_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lat_q <= MID;
                    out_q <= MID;
                end else begin
                    if (wr_en && (wr_sel == SEL_W'(c))) lat_q <= wr_code;
                    if (load) out_q <= lat_q;
                end
            end

            assign lat_bus[c*CODE_W +: CODE_W] = lat_q;
            assign out_bus[c*CODE_W +: CODE_W] = out_q;
        end
    endgenerate
endmodule

// File: rtl/sdac_load_if.sv
`timescale 1ns/1ps
module sdac_load_if
    import sdac_pkg::*;
#(
    parameter int CODE_W   = SDAC_CODE_W,
    parameter int SEL_W    = SDAC_SEL_W,
    parameter int NUM_CH   = SDAC_NUM_CH,
    parameter int SYNC     = SDAC_SYNC,
    localparam int BUS_W   = NUM_CH * CODE_W,
    localparam int FRAME_W = SEL_W + CODE_W,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             sdata_i,
    input  logic             latch_i,
    input  logic             pwrdn_n_i,
    output logic [BUS_W-1:0] code_o,
    output logic [BUS_W-1:0] code_signed_o,
    output logic             standby_o,
    output logic             frame_err_o
);
    logic [1:0]        edges;
    logic [1:0]        levels;
    logic              bit_rise, strobe_rise, bit_val;
    logic              wr_en;
    logic [SEL_W-1:0]  wr_sel;
    logic [CODE_W-1:0] wr_code;
    logic [BUS_W-1:0]  lat_bus;
    logic [CNT_W-1:0]  bit_cnt;

    sdac_sync #(.WIDTH(2), .STAGES(SYNC), .EDGE_OUT(1'b1)) u_edge_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({latch_i, sclk_i}), .sync_o(edges)
    );

    sdac_sync #(.WIDTH(2), .STAGES(SYNC), .EDGE_OUT(1'b0)) u_lvl_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({pwrdn_n_i, sdata_i}), .sync_o(levels)
    );

    assign bit_rise    = edges[0];
    assign strobe_rise = edges[1];
    assign bit_val     = levels[0];
    assign standby_o   = ~levels[1];

    sdac_frame_rx #(.SEL_W(SEL_W), .CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .bit_rise(bit_rise), .bit_val(bit_val), .strobe_rise(strobe_rise),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_code(wr_code),
        .frame_err(frame_err_o), .bit_cnt(bit_cnt)
    );

    sdac_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .SEL_W(SEL_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_code(wr_code),
        .load(strobe_rise), .lat_bus(lat_bus), .out_bus(code_o)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_signed
            assign code_signed_o[c*CODE_W +: CODE_W] =
                {~code_o[c*CODE_W + CODE_W - 1], code_o[c*CODE_W +: CODE_W-1]};
        end
    endgenerate
endmodule

// File: rtl/sdac_load_chk.sv
`timescale 1ns/1ps
module sdac_load_chk #(
    parameter int BUS_W   = 16,
    parameter int FRAME_W = 10,
    parameter int CNT_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strobe_rise,
    input logic [BUS_W-1:0] lat_bus,
    input logic [BUS_W-1:0] code_o,
    input logic             frame_err,
    input logic [CNT_W-1:0] bit_cnt
);
    // R2: the bit counter never reaches a full frame length
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bit_cnt) < FRAME_W);

    // R4: a strobe edge copies the staging latches as they stood
    p_load_copies_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_rise |=> (code_o == $past(lat_bus)));

    // R4: without a strobe edge the outputs hold
    p_hold_no_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_rise |=> $stable(code_o));

    // R5: the error flag is a single-cycle pulse
    p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    // R5: a rejected frame leaves the staging latches alone
    p_err_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> $stable(lat_bus));
endmodule

bind sdac_load_if sdac_load_chk #(
    .BUS_W(BUS_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .strobe_rise(strobe_rise),
    .lat_bus(lat_bus), .code_o(code_o), .frame_err(frame_err_o),
    .bit_cnt(bit_cnt)
);

// File: tb/tb_sdac_load_if.sv
`timescale 1ns/1ps
module tb_sdac_load_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, sdata = 1'b0, latch = 1'b0, pd_n = 1'b1;
    logic [15:0] code, code_s;
    logic        stby, ferr;

    int n_cmp = 0, n_bad = 0, err_seen = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sdac_load_if dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata),
        .latch_i(latch), .pwrdn_n_i(pd_n), .code_o(code),
        .code_signed_o(code_s), .standby_o(stby), .frame_err_o(ferr)
    );

    // Behavioural reference: histories of raw inputs, integer frame state
    int h_sc[3], h_la[3], h_sd[3], h_pd[3];
    int m_lat[2], m_out[2];
    int m_cnt, m_frame;
    bit m_pend, e_stby;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                h_sc[i] = 0; h_la[i] = 0; h_sd[i] = 0; h_pd[i] = 0;
            end
            m_lat[0] = 128; m_lat[1] = 128; m_out[0] = 128; m_out[1] = 128;
            m_cnt = 0; m_frame = 0; m_pend = 0; e_stby = 1;
        end else begin
            bit sr, lr, was;
            int dv;
            sr = (h_sc[1] == 1) && (h_sc[2] == 0);
            lr = (h_la[1] == 1) && (h_la[2] == 0);
            dv = h_sd[1];
            e_stby = (h_pd[0] == 0);
            was = m_pend;
            if (lr) begin
                m_out[0] = m_lat[0]; m_out[1] = m_lat[1];
            end
            if (was) begin
                if ((m_frame >> 8) < 2) m_lat[m_frame >> 8] = m_frame & 255;
                m_pend = 0;
            end else if (lr) begin
                m_cnt = 0;
            end else if (sr) begin
                m_frame = ((m_frame << 1) | dv) & 1023;
                m_cnt++;
                if (m_cnt == 10) begin m_pend = 1; m_cnt = 0; end
            end
            for (int i = 2; i > 0; i--) begin
                h_sc[i] = h_sc[i-1]; h_la[i] = h_la[i-1];
                h_sd[i] = h_sd[i-1]; h_pd[i] = h_pd[i-1];
            end
            h_sc[0] = int'(sclk); h_la[0] = int'(latch);
            h_sd[0] = int'(sdata); h_pd[0] = int'(pd_n);
        end
    end

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            int e_code;
            e_code = (m_out[1] << 8) | m_out[0];
            check("R3/R4 code_o per cycle", int'(code), e_code);
            check("R7 code_signed_o per cycle", int'(code_s), e_code ^ 16'h8080);
            check("R8 standby per cycle", int'(stby), int'(e_stby));
            check("R5 frame_err per cycle", int'(ferr),
                  int'(m_pend && ((m_frame >> 8) >= 2)));
            if (ferr) err_seen++;
        end
    end

    task automatic send_bits(int word, int nbits);
        for (int i = 9; i > 9 - nbits; i--) begin
            sdata = word[i];
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic send_frame(int sel, int val);
        send_bits((sel << 8) | val, 10);
    endtask

    task automatic strobe();
        latch = 1'b1;
        repeat (4) @(negedge clk);
        latch = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset code_o", int'(code), 16'h8080);
        check("R1 reset frame_err", int'(ferr), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 codes after release", int'(code), 16'h8080);

        send_frame(0, 8'h3C);
        send_frame(1, 8'hA5);
        check("R3 outputs wait for strobe", int'(code), 16'h8080);
        strobe();
        check("R4 both channels loaded", int'(code), 16'hA53C);
        check("R7 signed form", int'(code_s), 16'h25BC);

        send_frame(2, 8'h11);
        check("R5 one error pulse", err_seen, 1);
        strobe();
        check("R5 rejected frame ignored", int'(code), 16'hA53C);

        send_bits(10'h3FF, 5);
        strobe();
        send_frame(0, 8'h7F);
        send_frame(1, 8'h01);
        strobe();
        check("R6 partial frame discarded", int'(code[7:0]), 8'h7F);
        check("R2 msb-first ordering", int'(code[15:8]), 8'h01);

        pd_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 standby asserted", int'(stby), 1);
        send_frame(1, 8'hFE);
        strobe();
        check("R8 frames kept in standby", int'(code), 16'hFE7F);
        pd_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R8 standby released", int'(stby), 0);

        send_frame(3, 8'h55);
        send_frame(0, 8'h00);
        strobe();
        check("R5 select 3 rejected", err_seen, 2);
        check("R3 channel 0 code zero", int'(code), 16'hFE00);
        check("R7 signed of zero", int'(code_s), 16'h7E80);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule